// File: doc/BRIEF.md
# Microsequencer with Subroutine Stack

This block produces the next-state sequence for a hard-wired controller. A binary state register normally steps forward by one each clock. Control logic can also pick a different next state with a two-bit select code: a plain jump, a jump taken only when a condition input is true, or a return. The current state goes out to a downstream output-decode stage. That stage and the control-word store it drives are outside this block.

A group of states that is needed in several places is kept once, as a subroutine. A call command stores the address that follows the current state on a small hardware stack and then jumps to the subroutine's first state. A return takes the stored address back off the stack. The return point is known only at run time, so it cannot be coded into the controller. Overflow and underflow of the stack set a sticky error flag.

Top module: `mseq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is 0, the error flag clears and the stack empties. After reset, a return finds the stack empty.
- R2: Select code 0 with no call makes the next state the current state plus one, modulo 2^SW. With SW=5, state 31 is followed by 0.
- R3: Select code 1 with no call makes the next state `target_i`, whatever the value of `cond_i`.
- R4: Select code 2 with no call makes the next state `target_i` when `cond_i` is 1, and current state plus one when it is 0.
- R5: When `call_i` is 1 and the stack has room, current state plus one is pushed and the next state is `target_i`. The select code is ignored in that cycle.
- R6: Select code 3 with no call and a non-empty stack loads the most recently pushed entry into the state and removes it. Nested calls return in last-in, first-out order.
- R7: A call while DEPTH entries are held (default 4) still jumps to `target_i`. It pushes nothing, leaves the held entries unchanged, and sets the error flag.
- R8: A return with an empty stack makes the next state current state plus one, leaves the stack empty, and sets the error flag.
- R9: Once set, the error flag stays set until reset. Sequencing carries on normally while the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_i | input | 1 | Branch condition for select code 2 |
| sel_i | input | 2 | Next-state select: 0 step, 1 jump, 2 conditional jump, 3 return |
| target_i | input | SW | Jump or call target state |
| call_i | input | 1 | Subroutine call command, has priority over `sel_i` |
| state_o | output | SW | Current state, to the output decode stage |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench fills the stack to exactly DEPTH entries and then issues one more call. A design that let that push through would corrupt a return address or grow past its storage, and the following returns would then come back out of order. The bench also returns on an empty stack. A design without the guard would load a stale entry instead of stepping forward. Further checks cover:
- the increment wrapping from the highest state to 0;
- a call issued together with a return select code, which catches a design that gets the priority between them wrong;
- sequencing after the error is set, and a mid-run reset, which catch a flag that is not sticky or a stack that reset does not empty.

// File: rtl/mseq_pkg.sv
// Package: shared select-code type for the microsequencer.
// Assumes a two-bit select field driven by the surrounding control logic.
package mseq_pkg;
    typedef enum logic [1:0] {
        SEL_STEP   = 2'd0,
        SEL_JUMP   = 2'd1,
        SEL_BRANCH = 2'd2,
        SEL_RET    = 2'd3
    } sel_e;
endpackage

// File: rtl/mseq_stack.sv
// Return-address stack: a LIFO of DEPTH entries, each W bits wide.
// Assumes push and pop are never requested together, and never requested
// when full or empty respectively (the next-state logic guards this).
// Requests that arrive anyway in those cases are ignored.
module mseq_stack #(
    parameter int W     = 5,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH + 1);

    logic [PW-1:0] cnt_q;
    logic [W-1:0]  mem [DEPTH];

    assign full  = (cnt_q == PW'(DEPTH));
    assign empty = (cnt_q == '0);

    // Occupancy counter: up on an accepted push, down on an accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push && !full)
            cnt_q <= cnt_q + PW'(1);
        else if (pop && !empty)
            cnt_q <= cnt_q - PW'(1);
    end

    // One register per entry, written only when it is the next free slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (push && !full && cnt_q == PW'(i))
                mem[i] <= wdata;
        end
    end

    // Top-of-stack read: the most recently written occupied entry.
    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (cnt_q == PW'(i + 1))
                top = mem[i];
    end

    // R5: an accepted push raises occupancy by one and exposes the pushed value.
    p_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (cnt_q == $past(cnt_q) + PW'(1)) && (top == $past(wdata)));

    // R6: an accepted pop lowers occupancy by one.
    p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> (cnt_q == $past(cnt_q) - PW'(1)));

    // R7: a push while full leaves occupancy and top untouched.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> full && $stable(top));
endmodule

// File: rtl/mseq_nextstate.sv
// Next-state selection: combinational multiplexer choosing among the
// incremented state, the external target, and the stack top.
// Call has priority over the select code. A guarded stack request turns
// into a fault pulse instead of a push or pop.
module mseq_nextstate
    import mseq_pkg::*;
#(
    parameter int W = 5
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] target,
    input  logic [W-1:0] stk_top,
    input  logic [1:0]   sel,
    input  logic         cond,
    input  logic         call,
    input  logic         stk_full,
    input  logic         stk_empty,
    output logic [W-1:0] nxt,
    output logic [W-1:0] ret_addr,
    output logic         push,
    output logic         pop,
    output logic         fault
);
    logic [W-1:0] inc;
    sel_e         code;

    assign inc      = cur + W'(1);
    assign ret_addr = inc;
    assign code     = sel_e'(sel);

    // Next-state mux and stack request generation.
    always_comb begin
        nxt   = inc;
        push  = 1'b0;
        pop   = 1'b0;
        fault = 1'b0;
        if (call) begin
            nxt = target;
            if (stk_full) fault = 1'b1;
            else          push  = 1'b1;
        end else begin
            unique case (code)
                SEL_STEP:   nxt = inc;
                SEL_JUMP:   nxt = target;
                SEL_BRANCH: nxt = cond ? target : inc;
                SEL_RET: begin
                    if (stk_empty) begin
                        fault = 1'b1;
                        nxt   = inc;
                    end else begin
                        pop = 1'b1;
                        nxt = stk_top;
                    end
                end
                default:    nxt = inc;
            endcase
        end
    end
endmodule

// File: rtl/mseq_top.sv
// Microsequencer top: state register, sticky error flag, next-state mux
// and return-address stack. Assumes inputs are synchronous to clk.
// State encoding is binary, SW bits, so up to 2^SW states.
module mseq_top
    import mseq_pkg::*;
#(
    parameter int SW    = 5,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cond_i,
    input  logic [1:0]    sel_i,
    input  logic [SW-1:0] target_i,
    input  logic          call_i,
    output logic [SW-1:0] state_o,
    output logic          err_o
);
    logic [SW-1:0] state_q;
    logic          err_q;
    logic [SW-1:0] nxt;
    logic [SW-1:0] ret_addr;
    logic [SW-1:0] stk_top;
    logic          stk_full;
    logic          stk_empty;
    logic          push;
    logic          pop;
    logic          fault;

    mseq_nextstate #(.W(SW)) u_next (
        .cur       (state_q),
        .target    (target_i),
        .stk_top   (stk_top),
        .sel       (sel_i),
        .cond      (cond_i),
        .call      (call_i),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .nxt       (nxt),
        .ret_addr  (ret_addr),
        .push      (push),
        .pop       (pop),
        .fault     (fault)
    );

    mseq_stack #(.W(SW), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (ret_addr),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // State register: loads the selected next state every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= nxt;
    end

    // Sticky error flag: set on any stack fault, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     err_q <= 1'b0;
        else if (fault) err_q <= 1'b1;
    end

    assign state_o = state_q;
    assign err_o   = err_q;

    // R1: reset returns to state 0 with the flag clear.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0) && !err_q);

    // R2: step code advances by one.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && sel_i == SEL_STEP) |=> state_q == SW'($past(state_q) + SW'(1)));

    // R3: jump code loads the target.
    p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && sel_i == SEL_JUMP) |=> state_q == $past(target_i));

    // R4: conditional jump falls through when the condition is false.
    p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && sel_i == SEL_BRANCH && !cond_i) |=> state_q == SW'($past(state_q) + SW'(1)));

    // R5 and R7: a call always lands on the target.
    p_call_r5: assert property (@(posedge clk) disable iff (!rst_n)
        call_i |=> state_q == $past(target_i));

    // R7: a call on a full stack raises the flag.
    p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && stk_full) |=> err_q);

    // R8: return on an empty stack steps forward and raises the flag.
    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && sel_i == SEL_RET && stk_empty) |=> err_q && stk_empty &&
        state_q == SW'($past(state_q) + SW'(1)));

    // R9: the flag never clears outside reset.
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: tb/mseq_top_test.sv
// Bench: behavioural reference model (integer state, queue stack) compared
// with the design after every clock edge.
module mseq_top_test;
    localparam int PERIOD = 10;
    localparam int SW     = 5;
    localparam int DEPTH  = 4;
    localparam int NS     = 1 << SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cond_i = 1'b0;
    logic [1:0]    sel_i = 2'd0;
    logic [SW-1:0] target_i = '0;
    logic          call_i = 1'b0;
    logic [SW-1:0] state_o;
    logic          err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int m_state = 0;
    bit m_err   = 1'b0;
    int m_stk[$];

    mseq_top #(.SW(SW), .DEPTH(DEPTH)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond_i),
        .sel_i    (sel_i),
        .target_i (target_i),
        .call_i   (call_i),
        .state_o  (state_o),
        .err_o    (err_o)
    );

    always #(PERIOD / 2) clk = ~clk;

    // Reference model: one update per rising edge, from the requirements.
    task automatic model_tick();
        int inc;
        inc = (m_state + 1) % NS;
        if (!rst_n) begin
            m_state = 0;
            m_err   = 1'b0;
            m_stk.delete();
        end else if (call_i) begin
            if (m_stk.size() == DEPTH) m_err = 1'b1;
            else                       m_stk.push_back(inc);
            m_state = int'(target_i);
        end else begin
            case (sel_i)
                2'd0: m_state = inc;
                2'd1: m_state = int'(target_i);
                2'd2: m_state = cond_i ? int'(target_i) : inc;
                default: begin
                    if (m_stk.size() == 0) begin
                        m_err   = 1'b1;
                        m_state = inc;
                    end else begin
                        m_state = m_stk.pop_back();
                    end
                end
            endcase
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (int'(state_o) != m_state || err_o != m_err) begin
            fails++;
            $display("FAIL %s: state=%0d err=%0d expected state=%0d err=%0d",
                     tag, state_o, err_o, m_state, m_err);
        end
    endtask

    // Drive at the falling edge, update the model at the rising edge, sample 1 ns later.
    task automatic step(input bit rst, input logic [1:0] s, input bit c,
                        input bit cd, input int t, input string tag);
        @(negedge clk);
        rst_n    = ~rst;
        sel_i    = s;
        call_i   = c;
        cond_i   = cd;
        target_i = t[SW-1:0];
        @(posedge clk);
        model_tick();
        #1 check(tag);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(1, 0, 0, 0, 0, "R1 reset");
        step(1, 3, 1, 1, 9, "R1 reset");
        // R2 stepping and wrap
        step(0, 0, 0, 0, 0, "R2 step");
        step(0, 0, 0, 1, 7, "R2 step");
        step(0, 1, 0, 0, 30, "R3 jump cond0");
        step(0, 0, 0, 0, 0, "R2 step to 31");
        step(0, 0, 0, 0, 0, "R2 wrap to 0");
        step(0, 1, 0, 1, 12, "R3 jump cond1");
        step(0, 2, 0, 1, 20, "R4 taken");
        step(0, 2, 0, 0, 3, "R4 not taken");
        // R5 call overriding a return code, nested calls, R6 LIFO returns
        step(0, 3, 1, 0, 5, "R5 call over ret");
        step(0, 0, 1, 0, 9, "R5 nested call");
        step(0, 2, 1, 1, 14, "R5 nested call");
        step(0, 3, 0, 0, 0, "R6 return");
        step(0, 3, 0, 0, 0, "R6 return");
        step(0, 3, 0, 0, 0, "R6 return");
        // R7 fill to DEPTH then overflow
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 2 + 4 * i, "R7 fill");
        step(0, 1, 1, 0, 27, "R7 overflow call");
        step(0, 0, 0, 0, 0, "R9 step while flagged");
        for (int i = 0; i < DEPTH; i++) step(0, 3, 0, 0, 0, "R7 held entries");
        step(0, 3, 0, 0, 0, "R8 return empty");
        step(0, 0, 0, 0, 0, "R9 still set");
        // R1 reset clears the flag, R8 underflow from a fresh reset
        step(1, 0, 0, 0, 0, "R1 reset clears flag");
        step(0, 3, 0, 0, 0, "R8 underflow after reset");
        step(0, 0, 1, 0, 17, "R9 call while flagged");
        step(0, 3, 0, 0, 0, "R9 return while flagged");
        // Mixed stimulus
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 97) == 0, 2'($urandom % 4), ($urandom % 5) == 0,
                 1'($urandom % 2), int'($urandom % NS), "MIX R2 to R9");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule